// File: doc/BRIEF.md
# Realigning Instruction Queue with Bypass

This block sits between the instruction-word requester and the decode stage. It buffers whole 32-bit memory words together with an error flag. From the head of that stream it carves out the next instruction, which may be 16 or 32 bits long, and hands it to decode together with its program counter. When nothing is buffered, a word that arrives in the current cycle is decoded and presented on the output in that same cycle. Decode therefore sees no extra latency on a cold stream.

The instruction stream may begin on a half-word boundary. A 32-bit instruction whose first half sits in the upper half of one word is spliced with the lower half of the next word. It is only offered once both words are present. On a redirect, the clear input discards everything buffered and loads the program counter of the new stream. The requester checks the space flag before it launches a fetch, so a response that arrives is never refused half-way.

Top module: `fetch_realign_fifo`

## Requirements
- R1: After reset, `out_valid_o` is low, `has_space_o` is high, and the first instruction pushed is presented with PC equal to `RESET_PC` (default 0).
- R2: With nothing stored, a push with `push_valid_i` high makes `out_valid_o` high in the same cycle, with the pushed instruction and the current PC on the output.
- R3: Words pushed while decode is not ready are stored and later presented in arrival order, each with its own PC.
- R4: An instruction whose two lowest bits are not 2'b11 is 16 bits long. It is presented zero-extended in `out_instr_o[31:16]`. Consuming it advances the PC by 2, and the next instruction is taken from the other half of the same word.
- R5: An instruction whose two lowest bits are 2'b11 is 32 bits long. Consuming it advances the PC by 4.
- R6: When PC bit 1 is set and the upper half of the head word starts a 32-bit instruction, the output is {next word[15:0], head word[31:16]}. It is valid only once both words are present.
- R7: `out_err_o` is high when any word contributing to the presented instruction was pushed with `push_err_i` high.
- R8: In a cycle with `clear_i` high, `out_valid_o` is low and any push is dropped. In the next cycle nothing is stored, and the PC equals `clear_pc_i` with bit 0 forced to 0.
- R9: `has_space_o` is low exactly when `DEPTH` words are stored. A push while it is low is ignored.
- R10: While `out_valid_o` is high and `out_ready_i` is low, the next cycle keeps the same instruction, PC and error flag valid unless `clear_i` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Discard stored words and restart at `clear_pc_i` |
| clear_pc_i | input | PC_W | Program counter of the redirected stream |
| push_valid_i | input | 1 | A fetched word is arriving |
| push_rdata_i | input | 32 | Fetched memory word |
| push_err_i | input | 1 | The fetch of this word failed |
| has_space_o | output | 1 | At least one free word slot exists |
| out_valid_o | output | 1 | An instruction is presented to decode |
| out_ready_i | input | 1 | Decode takes the presented instruction |
| out_instr_o | output | 32 | Instruction, 16-bit ones zero-extended |
| out_pc_o | output | PC_W | Program counter of the presented instruction |
| out_err_o | output | 1 | A contributing word carried a fetch error |

## Verification
Five properties are checked on every cycle: the stored count never passes `DEPTH`; a valid output always has a word source; PC bit 0 stays clear; the PC lands on the redirect target and steps by 2 or 4 on every consumption; and a stalled output holds steady. The bench's scenarios are needed to show splicing across two words and its wait for the second word. They also show error merging from either half, same-cycle bypass content, ordering through a full queue, dropping of a push while full or during a clear, and the reset PC.

// File: rtl/fetch_realign_pkg.sv
package fetch_realign_pkg;

   localparam int unsigned WORD_W = 32;
   localparam int unsigned HALF_W = 16;

   typedef struct packed {
      logic              err;
      logic [WORD_W-1:0] word;
   } fetch_entry_t;

   // a half-word whose two lowest bits are not both set opens a 16-bit instruction
   function automatic logic opens_short(input logic [1:0] low_bits);
      return low_bits != 2'b11;
   endfunction

endpackage

// File: rtl/fetch_entry_store.sv
module fetch_entry_store
   import fetch_realign_pkg::*;
#(
   parameter int unsigned DEPTH = 3,
   parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clear_i,
   input  logic             push_i,
   input  fetch_entry_t     push_entry_i,
   input  logic             pop_i,
   output fetch_entry_t     head0_o,
   output fetch_entry_t     head1_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             space_o
);

   fetch_entry_t     slot_q [DEPTH];
   logic [CNT_W-1:0] cnt_q;
   logic             pop_slot;
   logic             keep_push;
   logic [CNT_W-1:0] wr_idx;

   // a pop with nothing stored consumes the bypassed word instead of a slot
   assign pop_slot  = pop_i && (cnt_q != '0);
   assign keep_push = push_i && !(pop_i && (cnt_q == '0));
   assign wr_idx    = cnt_q - CNT_W'(pop_slot);

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      fetch_entry_t shifted;
      if (i + 1 < DEPTH) begin : g_mid
         assign shifted = slot_q[i+1];
      end else begin : g_last
         assign shifted = slot_q[i];
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            slot_q[i] <= '0;
         end else if (keep_push && (wr_idx == CNT_W'(i))) begin
            slot_q[i] <= push_entry_i;
         end else if (pop_slot) begin
            slot_q[i] <= shifted;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (clear_i) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + CNT_W'(keep_push) - CNT_W'(pop_slot);
      end
   end

   assign head0_o = slot_q[0];
   assign head1_o = slot_q[1];
   assign cnt_o   = cnt_q;
   assign space_o = cnt_q < CNT_W'(DEPTH);

endmodule

// File: rtl/fetch_halfword_align.sv
module fetch_halfword_align
   import fetch_realign_pkg::*;
#(
   parameter int unsigned CNT_W = 2
) (
   input  logic              half_off_i,
   input  logic [CNT_W-1:0]  cnt_i,
   input  fetch_entry_t      head0_i,
   input  fetch_entry_t      head1_i,
   input  logic              push_i,
   input  fetch_entry_t      push_entry_i,
   input  logic              kill_i,
   input  logic              ready_i,
   output logic              valid_o,
   output logic [WORD_W-1:0] instr_o,
   output logic              err_o,
   output logic              short_o,
   output logic              fire_o,
   output logic              pop_o
);

   fetch_entry_t      w0;
   fetch_entry_t      w1;
   logic              w0_ok;
   logic              w1_ok;
   logic [HALF_W-1:0] first_half;
   logic              straddle;

   // window of two words: stored slots first, the arriving word fills the gap
   always_comb begin
      w0    = (cnt_i != '0) ? head0_i : push_entry_i;
      w0_ok = (cnt_i != '0) || push_i;
      w1    = (cnt_i >= CNT_W'(2)) ? head1_i : push_entry_i;
      w1_ok = (cnt_i >= CNT_W'(2)) || ((cnt_i == CNT_W'(1)) && push_i);
   end

   assign first_half = half_off_i ? w0.word[WORD_W-1:HALF_W] : w0.word[HALF_W-1:0];
   assign short_o    = opens_short(first_half[1:0]);
   assign straddle   = half_off_i && !short_o;

   always_comb begin
      if (short_o) begin
         instr_o = {{HALF_W{1'b0}}, first_half};
      end else if (half_off_i) begin
         instr_o = {w1.word[HALF_W-1:0], first_half};
      end else begin
         instr_o = w0.word;
      end
   end

   assign valid_o = w0_ok && (!straddle || w1_ok) && !kill_i;
   assign err_o   = w0.err || (straddle && w1.err);
   assign fire_o  = valid_o && ready_i;
   // the head word is used up when its upper half has been consumed
   assign pop_o   = fire_o && (half_off_i || !short_o);

endmodule

// File: rtl/fetch_realign_fifo.sv
module fetch_realign_fifo
   import fetch_realign_pkg::*;
#(
   parameter int unsigned    DEPTH    = 3,
   parameter int unsigned    PC_W     = 32,
   parameter logic [PC_W-1:0] RESET_PC = '0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clear_i,
   input  logic [PC_W-1:0]   clear_pc_i,
   input  logic              push_valid_i,
   input  logic [WORD_W-1:0] push_rdata_i,
   input  logic              push_err_i,
   output logic              has_space_o,
   output logic              out_valid_o,
   input  logic              out_ready_i,
   output logic [WORD_W-1:0] out_instr_o,
   output logic [PC_W-1:0]   out_pc_o,
   output logic              out_err_o
);

   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("fetch_realign_fifo: DEPTH must be at least 2 to splice two words");
   end
   if (PC_W < 2) begin : g_bad_pc
      $error("fetch_realign_fifo: PC_W must be at least 2");
   end

   fetch_entry_t     push_entry;
   fetch_entry_t     head0;
   fetch_entry_t     head1;
   logic [CNT_W-1:0] stored_cnt;
   logic             push_acc;
   logic             pop;
   logic             fire;
   logic             is_short;
   logic [PC_W-1:0]  pc_q;

   assign push_entry = '{err: push_err_i, word: push_rdata_i};
   assign push_acc   = push_valid_i && has_space_o && !clear_i;

   fetch_entry_store #(
      .DEPTH (DEPTH),
      .CNT_W (CNT_W)
   ) store_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .clear_i      (clear_i),
      .push_i       (push_acc),
      .push_entry_i (push_entry),
      .pop_i        (pop),
      .head0_o      (head0),
      .head1_o      (head1),
      .cnt_o        (stored_cnt),
      .space_o      (has_space_o)
   );

   fetch_halfword_align #(
      .CNT_W (CNT_W)
   ) align_i (
      .half_off_i   (pc_q[1]),
      .cnt_i        (stored_cnt),
      .head0_i      (head0),
      .head1_i      (head1),
      .push_i       (push_acc),
      .push_entry_i (push_entry),
      .kill_i       (clear_i),
      .ready_i      (out_ready_i),
      .valid_o      (out_valid_o),
      .instr_o      (out_instr_o),
      .err_o        (out_err_o),
      .short_o      (is_short),
      .fire_o       (fire),
      .pop_o        (pop)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pc_q <= {RESET_PC[PC_W-1:1], 1'b0};
      end else if (clear_i) begin
         pc_q <= {clear_pc_i[PC_W-1:1], 1'b0};
      end else if (fire) begin
         pc_q <= pc_q + (is_short ? PC_W'(2) : PC_W'(4));
      end
   end

   assign out_pc_o = pc_q;

endmodule

// File: rtl/fetch_realign_fifo_chk.sv
module fetch_realign_fifo_chk #(
   parameter int unsigned DEPTH = 3,
   parameter int unsigned PC_W  = 32,
   parameter int unsigned CNT_W = 2
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             clear_i,
   input logic [PC_W-1:0]  clear_pc_i,
   input logic             push_valid_i,
   input logic             out_valid_o,
   input logic             out_ready_i,
   input logic [31:0]      out_instr_o,
   input logic [PC_W-1:0]  out_pc_o,
   input logic             out_err_o,
   input logic [CNT_W-1:0] cnt_i
);

   // R9
   count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_i <= CNT_W'(DEPTH));

   // R2
   valid_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o |-> ((cnt_i != '0) || push_valid_i));

   // R8
   redirect_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clear_i |=> (out_pc_o == ($past(clear_pc_i) & ~PC_W'(1))));

   // R8
   pc_lsb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !out_pc_o[0]);

   // R4
   pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o && out_ready_i) |=> (clear_i ||
         out_pc_o == $past(out_pc_o) +
            (($past(out_instr_o[1:0]) != 2'b11) ? PC_W'(2) : PC_W'(4))));

   // R10
   stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o && !out_ready_i) |=> (clear_i || (out_valid_o &&
         $stable(out_instr_o) && $stable(out_pc_o) && $stable(out_err_o))));

endmodule

bind fetch_realign_fifo fetch_realign_fifo_chk #(
   .DEPTH (DEPTH),
   .PC_W  (PC_W),
   .CNT_W (CNT_W)
) chk_i (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .clear_i      (clear_i),
   .clear_pc_i   (clear_pc_i),
   .push_valid_i (push_valid_i),
   .out_valid_o  (out_valid_o),
   .out_ready_i  (out_ready_i),
   .out_instr_o  (out_instr_o),
   .out_pc_o     (out_pc_o),
   .out_err_o    (out_err_o),
   .cnt_i        (stored_cnt)
);

// File: tb/fetch_realign_fifo_tb.sv
module fetch_realign_fifo_tb_top;

   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic        clear_i = 1'b0;
   logic [31:0] clear_pc_i = '0;
   logic        push_valid_i = 1'b0;
   logic [31:0] push_rdata_i = '0;
   logic        push_err_i = 1'b0;
   logic        has_space_o;
   logic        out_valid_o;
   logic        out_ready_i = 1'b0;
   logic [31:0] out_instr_o;
   logic [31:0] out_pc_o;
   logic        out_err_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk_i = ~clk_i;

   fetch_realign_fifo dut_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .clear_i      (clear_i),
      .clear_pc_i   (clear_pc_i),
      .push_valid_i (push_valid_i),
      .push_rdata_i (push_rdata_i),
      .push_err_i   (push_err_i),
      .has_space_o  (has_space_o),
      .out_valid_o  (out_valid_o),
      .out_ready_i  (out_ready_i),
      .out_instr_o  (out_instr_o),
      .out_pc_o     (out_pc_o),
      .out_err_o    (out_err_o)
   );

   typedef struct packed {
      logic [15:0] tag;
      logic        clr;
      logic [31:0] cpc;
      logic        pv;
      logic [31:0] pd;
      logic        pe;
      logic        rdy;
      logic        ev;
      logic [31:0] ei;
      logic [31:0] ep;
      logic        ee;
      logic        sp;
   } vec_t;

   localparam int NV = 22;
   // inputs of the cycle, then the outputs expected before its rising edge
   localparam vec_t VEC [NV] = '{
      '{"R2", 1'b0, 32'h0, 1'b1, 32'h00A00093, 1'b0, 1'b1, 1'b1, 32'h00A00093, 32'h000, 1'b0, 1'b1},
      '{"R4", 1'b0, 32'h0, 1'b1, 32'h45054585, 1'b0, 1'b1, 1'b1, 32'h00004585, 32'h004, 1'b0, 1'b1},
      '{"R4", 1'b0, 32'h0, 1'b0, 32'h0,        1'b0, 1'b1, 1'b1, 32'h00004505, 32'h006, 1'b0, 1'b1},
      '{"R4", 1'b0, 32'h0, 1'b1, 32'h00B30505, 1'b0, 1'b1, 1'b1, 32'h00000505, 32'h008, 1'b0, 1'b1},
      '{"R6", 1'b0, 32'h0, 1'b0, 32'h0,        1'b0, 1'b1, 1'b0, 32'h0,        32'h000, 1'b0, 1'b1},
      '{"R6", 1'b0, 32'h0, 1'b1, 32'h00010040, 1'b0, 1'b1, 1'b1, 32'h004000B3, 32'h00A, 1'b0, 1'b1},
      '{"R4", 1'b0, 32'h0, 1'b0, 32'h0,        1'b0, 1'b1, 1'b1, 32'h00000001, 32'h00E, 1'b0, 1'b1},
      '{"R3", 1'b0, 32'h0, 1'b1, 32'h11111113, 1'b0, 1'b0, 1'b1, 32'h11111113, 32'h010, 1'b0, 1'b1},
      '{"R10",1'b0, 32'h0, 1'b1, 32'h22222223, 1'b0, 1'b0, 1'b1, 32'h11111113, 32'h010, 1'b0, 1'b1},
      '{"R10",1'b0, 32'h0, 1'b1, 32'h33333333, 1'b0, 1'b0, 1'b1, 32'h11111113, 32'h010, 1'b0, 1'b1},
      '{"R9", 1'b0, 32'h0, 1'b1, 32'h44444443, 1'b0, 1'b0, 1'b1, 32'h11111113, 32'h010, 1'b0, 1'b0},
      '{"R3", 1'b0, 32'h0, 1'b0, 32'h0,        1'b0, 1'b1, 1'b1, 32'h11111113, 32'h010, 1'b0, 1'b0},
      '{"R3", 1'b0, 32'h0, 1'b0, 32'h0,        1'b0, 1'b1, 1'b1, 32'h22222223, 32'h014, 1'b0, 1'b1},
      '{"R5", 1'b0, 32'h0, 1'b0, 32'h0,        1'b0, 1'b1, 1'b1, 32'h33333333, 32'h018, 1'b0, 1'b1},
      '{"R9", 1'b0, 32'h0, 1'b0, 32'h0,        1'b0, 1'b1, 1'b0, 32'h0,        32'h000, 1'b0, 1'b1},
      '{"R7", 1'b0, 32'h0, 1'b1, 32'h55555557, 1'b1, 1'b1, 1'b1, 32'h55555557, 32'h01C, 1'b1, 1'b1},
      '{"R8", 1'b1, 32'h103, 1'b1, 32'h99999993, 1'b0, 1'b1, 1'b0, 32'h0,      32'h000, 1'b0, 1'b1},
      '{"R8", 1'b0, 32'h0, 1'b1, 32'h00137777, 1'b1, 1'b1, 1'b0, 32'h0,        32'h000, 1'b0, 1'b1},
      '{"R7", 1'b0, 32'h0, 1'b1, 32'h00000ABC, 1'b0, 1'b1, 1'b1, 32'h0ABC0013, 32'h102, 1'b1, 1'b1},
      '{"R4", 1'b0, 32'h0, 1'b0, 32'h0,        1'b0, 1'b1, 1'b1, 32'h00000000, 32'h106, 1'b0, 1'b1},
      '{"R5", 1'b0, 32'h0, 1'b1, 32'hDEADBEEF, 1'b0, 1'b0, 1'b1, 32'hDEADBEEF, 32'h108, 1'b0, 1'b1},
      '{"R5", 1'b0, 32'h0, 1'b0, 32'h0,        1'b0, 1'b1, 1'b1, 32'hDEADBEEF, 32'h108, 1'b0, 1'b1}
   };

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic drive(input logic clr, input logic [31:0] cpc, input logic pv,
                        input logic [31:0] pd, input logic pe, input logic rdy);
      clear_i      = clr;
      clear_pc_i   = cpc;
      push_valid_i = pv;
      push_rdata_i = pd;
      push_err_i   = pe;
      out_ready_i  = rdy;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #(4 * 200000);
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk_i);
      // R1: reset state
      check("R1", "valid", 32'(out_valid_o), 32'h0);
      check("R1", "space", 32'(has_space_o), 32'h1);
      rst_ni = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk_i);
         drive(VEC[i].clr, VEC[i].cpc, VEC[i].pv, VEC[i].pd, VEC[i].pe, VEC[i].rdy);
         #1;
         check($sformatf("%s", VEC[i].tag), $sformatf("row%0d valid", i),
               32'(out_valid_o), 32'(VEC[i].ev));
         check($sformatf("%s", VEC[i].tag), $sformatf("row%0d space", i),
               32'(has_space_o), 32'(VEC[i].sp));
         if (VEC[i].ev) begin
            check($sformatf("%s", VEC[i].tag), $sformatf("row%0d instr", i),
                  out_instr_o, VEC[i].ei);
            check($sformatf("%s", VEC[i].tag), $sformatf("row%0d pc", i),
                  out_pc_o, VEC[i].ep);
            check($sformatf("%s", VEC[i].tag), $sformatf("row%0d err", i),
                  32'(out_err_o), 32'(VEC[i].ee));
         end
      end

      // R1: reset in the middle of a stalled stream empties the queue and restores the PC
      @(negedge clk_i);
      drive(1'b0, 32'h0, 1'b1, 32'h01234567, 1'b0, 1'b0);
      @(negedge clk_i);
      drive(1'b0, 32'h0, 1'b1, 32'h76543217, 1'b0, 1'b0);
      @(negedge clk_i);
      drive(1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0);
      rst_ni = 1'b0;
      #1;
      check("R1", "valid after reset", 32'(out_valid_o), 32'h0);
      check("R1", "space after reset", 32'(has_space_o), 32'h1);
      @(negedge clk_i);
      rst_ni = 1'b1;
      @(negedge clk_i);
      drive(1'b0, 32'h0, 1'b1, 32'h00000013, 1'b0, 1'b1);
      #1;
      check("R1", "first pc", out_pc_o, 32'h0);
      check("R1", "first instr", out_instr_o, 32'h00000013);
      @(negedge clk_i);
      drive(1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0);
      #1;
      check("R1", "drained", 32'(out_valid_o), 32'h0);

      finish_run();
   end

endmodule